// File: doc/BRIEF.md
# UART Bus Register and Interrupt Unit

This block is the processor-facing side of a UART. A processor reaches it through an APB slave port, with two-cycle transfers that have a setup phase and an access phase. Through that port the processor sets the baud divisor and the frame options (stop bits and parity). It pushes bytes into the transmit FIFO and pops bytes from the receive FIFO. It also programs and reads the interrupt state. The FIFOs and the serial engine are outside the block. The block connects to them through push/pop strobes, status flags and occupancy counts, and it exports its configuration as plain outputs.

Six interrupt conditions are derived live from FIFO status:
- transmit full
- receive full
- transmit empty
- receive empty
- transmit occupancy below a programmable watermark
- receive occupancy above a programmable watermark

The pending register shows these conditions directly and latches none of them. A single registered interrupt line is the OR of pending bits gated by an enable register. The reset values of the divisor, control and enable registers are parameters.

Top module: `uart_regbank`

## Requirements
- R1: While `rst` is high and after it falls, the divisor, control and enable registers hold the `RST_DIV`, `RST_CTRL` and `RST_IEN` parameter values. `irq` is low, `prdata` is zero and `pslverr` is low.
- R2: `pready` is always high. `prdata` and `pslverr` are valid in the access phase of each transfer. `pslverr` is high only while `psel` and `penable` are both high.
- R3: A write to offset 0x00 raises `tx_push` for exactly one cycle, in the access phase, with `tx_wdata` = `pwdata[7:0]`. If `tx_full` is high, no push happens and `pslverr` is set.
- R4: A read of offset 0x00 returns `rx_rdata` in bits 7:0, with the upper bits zero, and raises `rx_pop` for exactly one cycle. If `rx_empty` is high, no pop happens, `pslverr` is set and the read data is zero.
- R5: Offset 0x04 is the read/write divisor (`DIV_W` bits, from `pwdata[DIV_W-1:0]`). It drives `cfg_divisor` and changes only on a write to this offset.
- R6: Offset 0x08 is the read/write control register. Bit 0 selects two stop bits. Bit 1 enables parity. Bit 2 selects even parity (0 = odd). Bits 10:3 are the transmit watermark and bits 18:11 the receive watermark. Bits 0 to 2 drive `cfg_two_stop`, `cfg_parity_en` and `cfg_parity_even`. Bits 31:19 read as zero.
- R7: Offset 0x0C is the interrupt enable register, bits 5:0. Bits 31:6 are ignored on write and read as zero.
- R8: Offset 0x10 reads the live pending conditions with no latching. The bit order is 0 tx full, 1 rx full, 2 tx empty, 3 rx empty, 4 tx watermark, 5 rx watermark. A write to 0x10 sets `pslverr` and changes no register.
- R9: Pending bit 4 is set when `tx_level` is strictly less than the transmit watermark. Pending bit 5 is set when `rx_level` is strictly greater than the receive watermark.
- R10: `irq` is registered. One cycle after any change, it equals the OR over the six bits of (pending AND enable).
- R11: An access to an offset above 0x10, or to a non-word-aligned address, sets `pslverr`, reads as zero and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, registered |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Transfer error, registered |
| tx_push | output | 1 | Push strobe to the transmit FIFO |
| tx_wdata | output | 8 | Byte to push |
| tx_full | input | 1 | Transmit FIFO full |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_level | input | LVL_W | Transmit FIFO occupancy |
| rx_pop | output | 1 | Pop strobe to the receive FIFO |
| rx_rdata | input | 8 | Head of the receive FIFO |
| rx_full | input | 1 | Receive FIFO full |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| cfg_divisor | output | DIV_W | Clock-per-baud divisor |
| cfg_two_stop | output | 1 | Two stop bits selected |
| cfg_parity_en | output | 1 | Parity enabled |
| cfg_parity_even | output | 1 | Even parity selected |
| irq | output | 1 | Interrupt request, registered |

## Verification
The properties check four things on every cycle:
- no push ever meets a full transmit FIFO, and no pop meets an empty receive FIFO;
- a pop never lasts two cycles;
- an error only appears in the access phase;
- the divisor stays still without a write, and the interrupt line tracks the masked live conditions one cycle later.

The register layout, the read data, the watermark boundaries and the error decode can only be shown by the bench's transfers. This covers equal, one-below and one-above levels, unmapped and misaligned offsets, writes to the pending register, and random mixes of FIFO status and enable masks.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

  localparam int NUM_IRQ = 6;

  // Pending / enable bit positions
  localparam int IRQ_TX_FULL  = 0;
  localparam int IRQ_RX_FULL  = 1;
  localparam int IRQ_TX_EMPTY = 2;
  localparam int IRQ_RX_EMPTY = 3;
  localparam int IRQ_TX_LOW   = 4;
  localparam int IRQ_RX_HIGH  = 5;

  typedef enum logic [2:0] {
    SEL_DATA = 3'd0,
    SEL_DIV  = 3'd1,
    SEL_CTRL = 3'd2,
    SEL_IEN  = 3'd3,
    SEL_PEND = 3'd4,
    SEL_NONE = 3'd7
  } reg_sel_e;

  // Control word, bit 0 at the bottom
  typedef struct packed {
    logic [7:0] rx_wm;
    logic [7:0] tx_wm;
    logic       par_even;
    logic       par_en;
    logic       two_stop;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/uart_regbank_decode.sv
module uart_regbank_decode
  import uart_regbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] paddr,
  input  logic              pwrite,
  input  logic              tx_full,
  input  logic              rx_empty,
  output reg_sel_e          sel,
  output logic              err
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  assign idx = paddr[ADDR_W-1:2];

  always_comb begin
    sel = SEL_NONE;
    if (paddr[1:0] == 2'b00) begin
      case (idx)
        IDX_W'(0): sel = SEL_DATA;
        IDX_W'(1): sel = SEL_DIV;
        IDX_W'(2): sel = SEL_CTRL;
        IDX_W'(3): sel = SEL_IEN;
        IDX_W'(4): sel = SEL_PEND;
        default:   sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      SEL_NONE: err = 1'b1;
      SEL_PEND: err = pwrite;
      SEL_DATA: err = pwrite ? tx_full : rx_empty;
      default:  err = 1'b0;
    endcase
  end

endmodule

// File: rtl/uart_regbank_irq.sv
module uart_regbank_irq
  import uart_regbank_pkg::*;
#(
  parameter int LVL_W = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tx_full,
  input  logic               rx_full,
  input  logic               tx_empty,
  input  logic               rx_empty,
  input  logic [LVL_W-1:0]   tx_level,
  input  logic [LVL_W-1:0]   rx_level,
  input  logic [7:0]         tx_wm,
  input  logic [7:0]         rx_wm,
  input  logic [NUM_IRQ-1:0] ien,
  output logic [NUM_IRQ-1:0] pend,
  output logic               irq
);

  always_comb begin
    pend               = '0;
    pend[IRQ_TX_FULL]  = tx_full;
    pend[IRQ_RX_FULL]  = rx_full;
    pend[IRQ_TX_EMPTY] = tx_empty;
    pend[IRQ_RX_EMPTY] = rx_empty;
    pend[IRQ_TX_LOW]   = tx_level < LVL_W'(tx_wm);
    pend[IRQ_RX_HIGH]  = rx_level > LVL_W'(rx_wm);
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(pend & ien);
  end

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int                  ADDR_W   = 8,
  parameter int                  DIV_W    = 16,
  parameter int                  LVL_W    = 11,
  parameter logic [DIV_W-1:0]    RST_DIV  = 16'd434,
  parameter logic [18:0]         RST_CTRL = 19'h08080,
  parameter logic [5:0]          RST_IEN  = 6'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              tx_push,
  output logic [7:0]        tx_wdata,
  input  logic              tx_full,
  input  logic              tx_empty,
  input  logic [LVL_W-1:0]  tx_level,
  output logic              rx_pop,
  input  logic [7:0]        rx_rdata,
  input  logic              rx_full,
  input  logic              rx_empty,
  input  logic [LVL_W-1:0]  rx_level,
  output logic [DIV_W-1:0]  cfg_divisor,
  output logic              cfg_two_stop,
  output logic              cfg_parity_en,
  output logic              cfg_parity_even,
  output logic              irq
);

  logic setup_ph, access_ph;
  assign setup_ph  = psel & ~penable;
  assign access_ph = psel & penable;

  reg_sel_e           sel, sel_q;
  logic               dec_err, err_q;
  logic [DIV_W-1:0]   div_q;
  ctrl_t              ctrl_q;
  logic [NUM_IRQ-1:0] ien_q, pend;
  logic [31:0]        rd_mux, prdata_q;
  logic               wr_ok;
  logic               unused_wdata;

  assign unused_wdata = ^pwdata;

  uart_regbank_decode #(.ADDR_W(ADDR_W)) u_decode (
    .paddr    (paddr),
    .pwrite   (pwrite),
    .tx_full  (tx_full),
    .rx_empty (rx_empty),
    .sel      (sel),
    .err      (dec_err)
  );

  uart_regbank_irq #(.LVL_W(LVL_W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .tx_full  (tx_full),
    .rx_full  (rx_full),
    .tx_empty (tx_empty),
    .rx_empty (rx_empty),
    .tx_level (tx_level),
    .rx_level (rx_level),
    .tx_wm    (ctrl_q.tx_wm),
    .rx_wm    (ctrl_q.rx_wm),
    .ien      (ien_q),
    .pend     (pend),
    .irq      (irq)
  );

  // Read data chosen in the setup phase, presented in the access phase
  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_DATA: rd_mux = {24'd0, rx_rdata};
      SEL_DIV:  rd_mux = 32'(div_q);
      SEL_CTRL: rd_mux = 32'(ctrl_q);
      SEL_IEN:  rd_mux = 32'(ien_q);
      SEL_PEND: rd_mux = 32'(pend);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= SEL_NONE;
      err_q    <= 1'b0;
      prdata_q <= '0;
    end else if (setup_ph) begin
      sel_q    <= sel;
      err_q    <= dec_err;
      prdata_q <= (dec_err || pwrite) ? 32'd0 : rd_mux;
    end else begin
      err_q    <= 1'b0;
    end
  end

  assign wr_ok = access_ph & pwrite & ~err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= RST_DIV;
      ctrl_q <= ctrl_t'(RST_CTRL);
      ien_q  <= RST_IEN;
    end else if (wr_ok) begin
      case (sel_q)
        SEL_DIV:  div_q  <= pwdata[DIV_W-1:0];
        SEL_CTRL: ctrl_q <= ctrl_t'(pwdata[CTRL_W-1:0]);
        SEL_IEN:  ien_q  <= pwdata[NUM_IRQ-1:0];
        default:  ;
      endcase
    end
  end

  assign tx_push  = wr_ok & (sel_q == SEL_DATA);
  assign tx_wdata = pwdata[7:0];
  assign rx_pop   = access_ph & ~pwrite & ~err_q & (sel_q == SEL_DATA);

  assign prdata          = prdata_q;
  assign pslverr         = err_q;
  assign pready          = 1'b1;
  assign cfg_divisor     = div_q;
  assign cfg_two_stop    = ctrl_q.two_stop;
  assign cfg_parity_en   = ctrl_q.par_en;
  assign cfg_parity_even = ctrl_q.par_even;

endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk
  import uart_regbank_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int LVL_W = 11
) (
  input logic               clk,
  input logic               rst,
  input logic               psel,
  input logic               penable,
  input logic               pwrite,
  input logic               pslverr,
  input logic               tx_push,
  input logic               tx_full,
  input logic               tx_empty,
  input logic [LVL_W-1:0]   tx_level,
  input logic               rx_pop,
  input logic               rx_full,
  input logic               rx_empty,
  input logic [LVL_W-1:0]   rx_level,
  input ctrl_t              ctrl,
  input logic [NUM_IRQ-1:0] ien,
  input logic [DIV_W-1:0]   cfg_divisor,
  input logic               irq
);

  logic [NUM_IRQ-1:0] cond;
  assign cond = {rx_level > LVL_W'(ctrl.rx_wm), tx_level < LVL_W'(ctrl.tx_wm),
                 rx_empty, tx_empty, rx_full, tx_full};

  assert_err_access_R2: assert property (@(posedge clk) disable iff (rst)
    pslverr |-> (psel && penable));

  assert_push_not_full_R3: assert property (@(posedge clk) disable iff (rst)
    tx_push |-> (!tx_full && !pslverr));

  assert_pop_not_empty_R4: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> !rx_empty);

  assert_pop_single_R4: assert property (@(posedge clk) disable iff (rst)
    rx_pop |=> !rx_pop);

  assert_div_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(psel && penable && pwrite) |=> $stable(cfg_divisor));

  assert_irq_track_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == $past(|(cond & ien))));

endmodule

bind uart_regbank uart_regbank_chk #(.DIV_W(DIV_W), .LVL_W(LVL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .psel        (psel),
  .penable     (penable),
  .pwrite      (pwrite),
  .pslverr     (pslverr),
  .tx_push     (tx_push),
  .tx_full     (tx_full),
  .tx_empty    (tx_empty),
  .tx_level    (tx_level),
  .rx_pop      (rx_pop),
  .rx_full     (rx_full),
  .rx_empty    (rx_empty),
  .rx_level    (rx_level),
  .ctrl        (ctrl_q),
  .ien         (ien_q),
  .cfg_divisor (cfg_divisor),
  .irq         (irq)
);

// File: tb/uart_regbank_bench.sv
`timescale 1ns/1ps
module uart_regbank_bench;

  localparam int ADDR_W = 8;
  localparam int DIV_W  = 16;
  localparam int LVL_W  = 11;
  localparam logic [DIV_W-1:0] RST_DIV  = 16'd434;
  localparam logic [18:0]      RST_CTRL = 19'h08080;
  localparam logic [5:0]       RST_IEN  = 6'h00;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr, tx_push, rx_pop, irq;
  logic [7:0] tx_wdata;
  logic tx_full = 0, tx_empty = 1, rx_full = 0, rx_empty = 1;
  logic [LVL_W-1:0] tx_level = '0, rx_level = '0;
  logic [7:0] rx_rdata = 8'h00;
  logic [DIV_W-1:0] cfg_divisor;
  logic cfg_two_stop, cfg_parity_en, cfg_parity_even;

  int tests = 0, fails = 0;
  int push_cnt = 0, pop_cnt = 0;
  logic [7:0] last_push = '0;

  // shadow of programmed state
  logic [18:0] sh_ctrl = RST_CTRL;
  logic [5:0]  sh_ien  = RST_IEN;

  always #2 clk = ~clk;

  uart_regbank #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .LVL_W(LVL_W),
                 .RST_DIV(RST_DIV), .RST_CTRL(RST_CTRL), .RST_IEN(RST_IEN)) u_uart_regbank (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_full(tx_full), .tx_empty(tx_empty),
    .tx_level(tx_level), .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_full(rx_full),
    .rx_empty(rx_empty), .rx_level(rx_level), .cfg_divisor(cfg_divisor),
    .cfg_two_stop(cfg_two_stop), .cfg_parity_en(cfg_parity_en),
    .cfg_parity_even(cfg_parity_even), .irq(irq));

  always @(negedge clk) begin
    if (tx_push) begin push_cnt++; last_push = tx_wdata; end
    if (rx_pop) pop_cnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] pend_model(input logic [18:0] c);
    pend_model = {rx_level > LVL_W'(c[18:11]), tx_level < LVL_W'(c[10:3]),
                  rx_empty, tx_empty, rx_full, tx_full};
  endfunction

  task automatic apb(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                     output logic [31:0] rd, output logic er);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = wd;
    @(negedge clk);
    penable = 1;
    rd = prdata; er = pslverr;
    check("R2 pready", 32'(pready), 32'd1);
    @(negedge clk);
    psel = 0; penable = 0;
    if (wr && !er) begin
      if (a == 8'h08) sh_ctrl = wd[18:0];
      if (a == 8'h0C) sh_ien = wd[5:0];
    end
  endtask

  logic [31:0] rd;
  logic er;
  int p0, q0;

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 prdata", prdata, 32'd0);
    check("R1 pslverr", 32'(pslverr), 32'd0);
    check("R1 divisor", 32'(cfg_divisor), 32'(RST_DIV));
    rst = 0;
    apb(0, 8'h04, 0, rd, er); check("R1 div read", rd, 32'(RST_DIV));
    apb(0, 8'h08, 0, rd, er); check("R1 ctrl read", rd, 32'(RST_CTRL));
    apb(0, 8'h0C, 0, rd, er); check("R1 ien read", rd, 32'(RST_IEN));

    // R5 divisor
    apb(1, 8'h04, 32'hFFFF_1B2C, rd, er);
    check("R5 no err", 32'(er), 0);
    check("R5 cfg_divisor", 32'(cfg_divisor), 32'h1B2C);
    apb(0, 8'h04, 0, rd, er); check("R5 readback", rd, 32'h1B2C);

    // R6 control
    apb(1, 8'h08, 32'hFFFF_FFFD, rd, er);
    apb(0, 8'h08, 0, rd, er); check("R6 readback", rd, 32'h0007_FFFD);
    check("R6 two_stop", 32'(cfg_two_stop), 1);
    check("R6 parity_en", 32'(cfg_parity_en), 0);
    check("R6 parity_even", 32'(cfg_parity_even), 1);
    apb(1, 8'h08, 32'h0000_0002, rd, er);
    check("R6 parity_en set", {cfg_two_stop, cfg_parity_en, cfg_parity_even}, 32'b010);

    // R7 enable, upper bits ignored
    apb(1, 8'h0C, 32'hFFFF_FFC0, rd, er);
    apb(0, 8'h0C, 0, rd, er); check("R7 upper ignored", rd, 32'd0);
    apb(1, 8'h0C, 32'h0000_002A, rd, er);
    apb(0, 8'h0C, 0, rd, er); check("R7 readback", rd, 32'h2A);

    // R3 data write
    tx_full = 0; p0 = push_cnt;
    apb(1, 8'h00, 32'hABCD_EF5A, rd, er);
    check("R3 one push", 32'(push_cnt - p0), 1);
    check("R3 push data", 32'(last_push), 32'h5A);
    check("R3 no err", 32'(er), 0);
    tx_full = 1; p0 = push_cnt;
    apb(1, 8'h00, 32'h0000_0011, rd, er);
    check("R3 full err", 32'(er), 1);
    check("R3 full no push", 32'(push_cnt - p0), 0);
    tx_full = 0;

    // R4 data read
    rx_empty = 0; rx_rdata = 8'hC3; q0 = pop_cnt;
    apb(0, 8'h00, 0, rd, er);
    check("R4 data", rd, 32'h0000_00C3);
    check("R4 one pop", 32'(pop_cnt - q0), 1);
    rx_empty = 1; q0 = pop_cnt;
    apb(0, 8'h00, 0, rd, er);
    check("R4 empty err", 32'(er), 1);
    check("R4 empty data", rd, 0);
    check("R4 empty no pop", 32'(pop_cnt - q0), 0);

    // R11 unmapped / misaligned, R8 pending write
    apb(1, 8'h14, 32'hFFFF_FFFF, rd, er); check("R11 unmapped write err", 32'(er), 1);
    apb(1, 8'h06, 32'h0000_0001, rd, er); check("R11 misaligned err", 32'(er), 1);
    apb(0, 8'h1C, 0, rd, er); check("R11 unmapped read err", 32'(er), 1);
    check("R11 unmapped read zero", rd, 0);
    apb(1, 8'h10, 32'hFFFF_FFFF, rd, er); check("R8 pending write err", 32'(er), 1);
    apb(0, 8'h04, 0, rd, er); check("R11 div untouched", rd, 32'h1B2C);
    apb(0, 8'h08, 0, rd, er); check("R11 ctrl untouched", rd, 32'h2);
    apb(0, 8'h0C, 0, rd, er); check("R8 ien untouched", rd, 32'h2A);

    // R9 watermark boundaries: tx_wm = 20, rx_wm = 30
    apb(1, 8'h08, {13'd0, 8'd30, 8'd20, 3'b000}, rd, er);
    apb(1, 8'h0C, 32'h30, rd, er);
    tx_full = 0; tx_empty = 0; rx_full = 0; rx_empty = 0;
    tx_level = 20; rx_level = 30;
    apb(0, 8'h10, 0, rd, er); check("R9 equal levels", rd, 32'h00);
    @(negedge clk); check("R10 irq clear", 32'(irq), 0);
    tx_level = 19;
    apb(0, 8'h10, 0, rd, er); check("R9 tx below", rd, 32'h10);
    @(negedge clk); check("R10 irq tx low", 32'(irq), 1);
    tx_level = 20; rx_level = 31;
    apb(0, 8'h10, 0, rd, er); check("R9 rx above", rd, 32'h20);
    rx_level = 30;
    @(negedge clk); @(negedge clk); check("R10 irq drops", 32'(irq), 0);

    // R8 / R10 random status mixes
    for (int i = 0; i < 60; i++) begin
      tx_full  = 1'($urandom); rx_full  = 1'($urandom);
      tx_empty = 1'($urandom); rx_empty = 1'($urandom);
      tx_level = LVL_W'($urandom_range(0, 300));
      rx_level = LVL_W'($urandom_range(0, 300));
      if (i % 4 == 0)
        apb(1, 8'h08, {13'd0, 8'($urandom), 8'($urandom), 3'($urandom)}, rd, er);
      if (i % 3 == 0)
        apb(1, 8'h0C, 32'($urandom), rd, er);
      apb(0, 8'h10, 0, rd, er);
      check("R8 pending live", rd, 32'(pend_model(sh_ctrl)));
      @(negedge clk);
      check("R10 irq mask", 32'(irq), 32'(|(pend_model(sh_ctrl) & sh_ien)));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule